// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital control sequencer for a 12-bit successive-approximation converter. Reset starts a fixed power-up calibration phase. When that phase ends, the block waits for single-cycle start requests. Each request names one of 32 input channels.

An accepted request runs three phases:
- a sample phase whose length is programmable;
- a 12-step binary search that resolves one result bit per clock from a comparator input;
- one post-conversion calibration slot.

The calibration slots rotate through the offset trim and each bit of the capacitor array. The block drives the sample, busy and result-valid status lines. It holds the converted code until a later conversion replaces it.

The analog array and comparator sit outside the block. The sequencer presents a trial code, and the comparator answers whether the analog input is at or above that code. Computing trim values is also outside the block. The sequencer only passes an externally supplied 8-bit trim code through during the post-calibration slot and reports which slot is running.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset is released, `cal_o` stays high for exactly 3,840 clock cycles. No conversion can begin while it is high.
- R2: A start accepted while idle latches `chan_i`. The latched channel appears on `chan_sel_o` for the whole sample phase, and `chan_sel_o` is 0 at all other times.
- R3: On the clock edge that accepts a start, `sample_o` and `busy_o` rise together and `valid_o` clears.
- R4: The sample phase lasts `sample_len_i + 2` clocks, using the value latched at the start. It is followed by exactly 12 clocks with `busy_o` high and `sample_o` low. Step k offers `trial_o` = the bits decided so far, with bit 11-k set. `cmp_i` = 1 means the input is at or above the trial code, and keeps that bit. Bits are decided MSB first.
- R5: On the edge that ends the 12th decision, `busy_o` falls and `valid_o` rises. `result_o` then equals the code found by the search.
- R6: `valid_o` stays high until the next accepted start and clears on that start's edge.
- R7: `result_o` changes only on the edge where `valid_o` rises. It is held through idle time and through the whole of the next conversion.
- R8: Each conversion is followed by one post-calibration clock with `postcal_o` high. `postcal_slot_o` gives the slot: 0 = offset, and k = 1..12 = array bit 12-k. The slot advances by one after each conversion and wraps from 12 back to 0. The first conversion after reset uses slot 0.
- R9: `trim_o` equals `trim_i` while `postcal_o` is high and is 0 otherwise.
- R10: A start that arrives during calibration, sampling, conversion or post-calibration is ignored. It produces a one-clock `start_dropped_o` pulse on the following clock.
- R11: During reset, `cal_o` is 1 and `sample_o`, `busy_o`, `valid_o`, `postcal_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle conversion request |
| chan_i | input | 5 | Channel to convert, latched at start |
| sample_len_i | input | 8 | Sample phase length minus 2, latched at start |
| cmp_i | input | 1 | Comparator: 1 when input is at or above `trial_o` |
| trim_i | input | 8 | Calibration code for the post-calibration slot |
| cal_o | output | 1 | Power-up calibration in progress |
| sample_o | output | 1 | Sample-and-hold phase |
| busy_o | output | 1 | Sampling or converting |
| valid_o | output | 1 | Result holds a completed conversion |
| result_o | output | 12 | Latched conversion code |
| trial_o | output | 12 | Trial code for the comparator, 0 outside conversion |
| chan_sel_o | output | 5 | Channel select during sampling, 0 otherwise |
| postcal_o | output | 1 | Post-calibration slot active |
| postcal_slot_o | output | 4 | Slot being calibrated (0 offset, k = bit 12-k) |
| trim_o | output | 8 | Trim code applied during post-calibration |
| start_dropped_o | output | 1 | One-clock pulse for an ignored start |

## Verification
The assertions assume that `start_i` is a clean synchronous level and that `cmp_i` settles within the clock in which `trial_o` is shown. They also assume reset is held for at least one edge before any check matters.

The stimulus drives all inputs on the falling edge, so they are stable at every rising edge. A comparator in the bench derives `cmp_i` combinationally from the current `trial_o` and a target code, which satisfies the settling assumption. Starts are raised for a single clock only. Deliberately misplaced starts are sent during calibration and during a conversion to exercise the ignore path.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_CAL     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_SAMPLE  = 3'd2,
    ST_CONV    = 3'd3,
    ST_POSTCAL = 3'd4
  } seq_state_t;

endpackage

// File: rtl/sar_cal_timer.sv
module sar_cal_timer #(
  parameter int CAL_CYCLES = 3840
) (
  input  logic clk,
  input  logic rst,
  output logic cal_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CAL_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CAL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             cal_q;

  assign done_o = cal_q && (cnt_q == LAST);
  assign cal_o  = cal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cal_q <= 1'b1;
    end else if (cal_q) begin
      if (done_o) begin
        cal_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R1: calibration ends only after the full count
  p_cal_len_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(cal_q) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] code_o,
  output logic             last_o
);
  localparam int IDX_W = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] sar_q;
  logic [IDX_W-1:0] idx_q;
  logic [WIDTH-1:0] mask;

  assign mask    = ONE << idx_q;
  assign trial_o = sar_q | mask;
  assign code_o  = cmp_i ? trial_o : sar_q;
  assign last_o  = (idx_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sar_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sar_q <= '0;
      idx_q <= IDX_W'(WIDTH - 1);
    end else if (step_i) begin
      sar_q <= code_o;
      if (!last_o) idx_q <= idx_q - IDX_W'(1);
    end
  end

  // R4: search opens with only the MSB set
  p_msb_first_r4: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (trial_o == (ONE << (WIDTH - 1))));

endmodule

// File: rtl/sar_postcal_rotator.sv
module sar_postcal_rotator #(
  parameter int WIDTH = 12,
  parameter int SLOT_W = $clog2(WIDTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance_i,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] TOP = SLOT_W'(WIDTH);

  logic [SLOT_W-1:0] slot_q;
  assign slot_o = slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (advance_i) begin
      slot_q <= (slot_q == TOP) ? '0 : slot_q + SLOT_W'(1);
    end
  end

  // R8: slot stays within offset plus one per array bit
  p_slot_range_r8: assert property (@(posedge clk) disable iff (rst)
    slot_q <= TOP);

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter int CH_W       = 5,
  parameter int SLEN_W     = 8,
  parameter int TRIM_W     = 8,
  parameter int CAL_CYCLES = 3840,
  parameter int SLOT_W     = $clog2(RES_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [SLEN_W-1:0] sample_len_i,
  input  logic              cmp_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic              cal_o,
  output logic              sample_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic [RES_W-1:0]  result_o,
  output logic [RES_W-1:0]  trial_o,
  output logic [CH_W-1:0]   chan_sel_o,
  output logic              postcal_o,
  output logic [SLOT_W-1:0] postcal_slot_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic              start_dropped_o
);
  localparam int SC_W = SLEN_W + 1;

  seq_state_t        state_q;
  logic [SC_W-1:0]   samp_cnt_q;
  logic [SLEN_W-1:0] len_q;
  logic [CH_W-1:0]   chan_q;
  logic              valid_q;
  logic [RES_W-1:0]  result_q;
  logic              dropped_q;

  logic              cal_done;
  logic              accept;
  logic              samp_last;
  logic              conv_step;
  logic              conv_last;
  logic [RES_W-1:0]  eng_trial;
  logic [RES_W-1:0]  eng_code;

  sar_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk    (clk),
    .rst    (rst),
    .cal_o  (cal_o),
    .done_o (cal_done)
  );

  assign accept    = start_i && (state_q == ST_IDLE);
  assign samp_last = (state_q == ST_SAMPLE) &&
                     (samp_cnt_q == ({1'b0, len_q} + SC_W'(1)));
  assign conv_step = (state_q == ST_CONV);

  sar_bit_engine #(.WIDTH(RES_W)) u_bits (
    .clk     (clk),
    .rst     (rst),
    .load_i  (samp_last),
    .step_i  (conv_step),
    .cmp_i   (cmp_i),
    .trial_o (eng_trial),
    .code_o  (eng_code),
    .last_o  (conv_last)
  );

  sar_postcal_rotator #(.WIDTH(RES_W), .SLOT_W(SLOT_W)) u_rot (
    .clk       (clk),
    .rst       (rst),
    .advance_i (state_q == ST_POSTCAL),
    .slot_o    (postcal_slot_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_CAL;
      samp_cnt_q <= '0;
      len_q      <= '0;
      chan_q     <= '0;
      valid_q    <= 1'b0;
      result_q   <= '0;
      dropped_q  <= 1'b0;
    end else begin
      dropped_q <= start_i && (state_q != ST_IDLE);
      case (state_q)
        ST_CAL: begin
          if (cal_done) state_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (accept) begin
            state_q    <= ST_SAMPLE;
            samp_cnt_q <= '0;
            len_q      <= sample_len_i;
            chan_q     <= chan_i;
            valid_q    <= 1'b0;
          end
        end
        ST_SAMPLE: begin
          samp_cnt_q <= samp_cnt_q + SC_W'(1);
          if (samp_last) state_q <= ST_CONV;
        end
        ST_CONV: begin
          if (conv_last) begin
            state_q  <= ST_POSTCAL;
            result_q <= eng_code;
            valid_q  <= 1'b1;
          end
        end
        ST_POSTCAL: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sample_o        = (state_q == ST_SAMPLE);
  assign busy_o          = (state_q == ST_SAMPLE) || (state_q == ST_CONV);
  assign postcal_o       = (state_q == ST_POSTCAL);
  assign valid_o         = valid_q;
  assign result_o        = result_q;
  assign trial_o         = conv_step ? eng_trial : '0;
  assign chan_sel_o      = sample_o ? chan_q : '0;
  assign trim_o          = postcal_o ? trim_i : '0;
  assign start_dropped_o = dropped_q;

  // R1: no activity while calibrating
  p_cal_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    cal_o |-> (!busy_o && !valid_o && !postcal_o));

  // R3: sample and busy rise together
  p_sample_busy_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_o) |-> $rose(busy_o));

  // R4: busy continues after sampling ends
  p_busy_after_sample_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(sample_o) |-> busy_o);

  // R5: end of conversion raises valid and opens post-calibration
  p_done_valid_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (valid_o && postcal_o));

  // R6: valid only clears on a start request
  p_valid_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(valid_o) |-> $past(start_i));

  // R7: result only moves when valid rises
  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$rose(valid_o) |-> $stable(result_o));

  // R10: start during calibration is ignored and reported
  p_drop_cal_r10: assert property (@(posedge clk) disable iff (rst)
    (start_i && cal_o) |=> (start_dropped_o && !sample_o));

endmodule

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic [4:0]  chan_i;
  logic [7:0]  sample_len_i;
  logic        cmp_i;
  logic [7:0]  trim_i;
  logic        cal_o, sample_o, busy_o, valid_o, postcal_o, start_dropped_o;
  logic [11:0] result_o, trial_o;
  logic [4:0]  chan_sel_o;
  logic [3:0]  postcal_slot_o;
  logic [7:0]  trim_o;

  logic [11:0] vin;
  int          n_chk = 0;
  int          n_fail = 0;
  int          exp_slot = 0;
  logic [11:0] prev_res = '0;
  bit          finished = 0;

  always #10 clk = ~clk;

  assign cmp_i = (vin >= trial_o);

  sar_conv_seq dut (
    .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i),
    .sample_len_i(sample_len_i), .cmp_i(cmp_i), .trim_i(trim_i),
    .cal_o(cal_o), .sample_o(sample_o), .busy_o(busy_o), .valid_o(valid_o),
    .result_o(result_o), .trial_o(trial_o), .chan_sel_o(chan_sel_o),
    .postcal_o(postcal_o), .postcal_slot_o(postcal_slot_o), .trim_o(trim_o),
    .start_dropped_o(start_dropped_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset_cal();
    int n;
    rst = 1; start_i = 0; chan_i = 0; sample_len_i = 0; trim_i = 0; vin = 0;
    repeat (3) @(negedge clk);
    check(cal_o == 1, "R11 cal", cal_o, 1);
    check({sample_o, busy_o, valid_o, postcal_o} == 0, "R11 status", {sample_o, busy_o, valid_o, postcal_o}, 0);
    check(result_o == 0, "R11 result", result_o, 0);
    rst = 0;
    n = 0;
    while (cal_o === 1'b1 && n < 5000) begin
      n++;
      if (n == 101) check(start_dropped_o == 1, "R10 drop in cal", start_dropped_o, 1);
      if (n == 102) check(start_dropped_o == 0, "R10 one-clock pulse", start_dropped_o, 0);
      check(busy_o == 0, "R1 no conversion in cal", busy_o, 0);
      start_i = (n == 100);
      @(negedge clk);
    end
    start_i = 0;
    check(n == 3840, "R1 cal length", n, 3840);
    check(busy_o == 0 && valid_o == 0, "R1 idle after cal", busy_o, 0);
  endtask

  task automatic t_convert(input logic [11:0] val, input logic [7:0] len,
                           input logic [4:0] ch, input logic [7:0] trim, input bit poke);
    int ns, nb;
    bit ch_ok;
    vin = val; sample_len_i = len; chan_i = ch; trim_i = trim;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    check(sample_o == 1 && busy_o == 1, "R3 sample+busy", {sample_o, busy_o}, 3);
    check(valid_o == 0, "R6 valid clears on start", valid_o, 0);
    sample_len_i = ~len; chan_i = ~ch;
    ns = 0; ch_ok = 1;
    while (sample_o === 1'b1 && ns < 400) begin
      ns++;
      if (chan_sel_o != ch) ch_ok = 0;
      if (result_o != prev_res) check(0, "R7 hold in sample", result_o, prev_res);
      @(negedge clk);
    end
    check(ch_ok, "R2 channel during sample", chan_sel_o, ch);
    check(ns == int'(len) + 2, "R4 sample length", ns, int'(len) + 2);
    nb = 0;
    while (busy_o === 1'b1 && nb < 40) begin
      nb++;
      if (poke && nb == 4) check(start_dropped_o == 1, "R10 drop in conv", start_dropped_o, 1);
      start_i = poke && (nb == 3);
      if (sample_o != 0) check(0, "R4 sample low in conv", sample_o, 0);
      if (result_o != prev_res) check(0, "R7 hold in conv", result_o, prev_res);
      @(negedge clk);
    end
    start_i = 0;
    check(nb == 12, "R4 conversion clocks", nb, 12);
    check(valid_o == 1, "R5 valid", valid_o, 1);
    check(result_o == val, "R5 result", result_o, val);
    check(postcal_o == 1, "R8 postcal", postcal_o, 1);
    check(postcal_slot_o == exp_slot, "R8 slot", postcal_slot_o, exp_slot);
    check(trim_o == trim, "R9 trim pass", trim_o, trim);
    check(chan_sel_o == 0, "R2 channel off", chan_sel_o, 0);
    @(negedge clk);
    check(postcal_o == 0 && trim_o == 0, "R9 trim off", trim_o, 0);
    check(valid_o == 1 && result_o == val, "R6 valid held", result_o, val);
    exp_slot = (exp_slot == 12) ? 0 : exp_slot + 1;
    prev_res = val;
  endtask

  task automatic t_idle_hold(input int cycles);
    vin = ~vin;
    repeat (cycles) begin
      @(negedge clk);
      if (valid_o != 1 || result_o != prev_res) check(0, "R6 R7 idle hold", result_o, prev_res);
    end
    check(valid_o == 1 && result_o == prev_res, "R7 idle hold", result_o, prev_res);
  endtask

  initial begin
    t_reset_cal();
    t_convert(12'hA5C, 8'd0,   5'd3,  8'h3C, 0);
    t_idle_hold(10);
    t_convert(12'h000, 8'd255, 5'd31, 8'h81, 0);
    t_convert(12'hFFF, 8'd3,   5'd7,  8'hFF, 1);
    t_convert(12'h800, 8'd10,  5'd0,  8'h01, 0);
    t_idle_hold(5);
    t_convert(12'h7FF, 8'd1,   5'd16, 8'h5A, 0);
    for (int k = 0; k < 10; k++) begin
      t_convert(12'((k * 12'h123 + 12'h055) & 12'hFFF), 8'(k), 5'(k + 9), 8'(k * 17), k == 4);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule